// File: doc/BRIEF.md
# Grouped Interrupt Priority Controller

This block gathers interrupt requests from on-chip peripherals into a sticky 16-bit status register. A 16-bit enable register masks that status. The masked sources are folded into fixed groups, and each group drives one numbered line towards the processor. A separate enable/status pair serves the video unit and drives line 0. The block picks the lowest-numbered pending line and presents it, registered, as a normal interrupt request with a line number.

The block also owns the in-service state of the processor's two interrupt classes, normal and fast. A normal request is offered only when the global normal enable is on and nothing is in service. The fast request is offered whenever its own enable is on and no fast interrupt is in service. The processor acknowledges a request with a pulse and leaves the handler with a return pulse.

Top module: `gipc_top`

## Requirements
- R1: After reset all four registers are zero, and irqReq, irqLine, fiqReq, irqActive, fiqActive and pendLines are zero.
- R2: A bit of the source status register is set by a one on srcSet and stays set until it is written with a one at regAddr 1 (write-one-to-clear). If a set pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: A write to regAddr 0 loads the source enable register. A write to regAddr 2 loads the video enable register. A write to regAddr 3 clears video status bits by write-one-to-clear. The vidSet pulses set video status bits, and the result is visible on vidStatusOut.
- R4: Each bit of pendLines reflects its own group of the masked sources. Line 0 is any bit of video enable AND video status. The other lines use source enable AND status ANDed with a group mask: line 2 uses 0x0C00, line 3 uses 0x2100, line 5 uses 0x1200, line 6 uses 0x0070 and line 7 uses 0x008B. Lines 1 and 4 never assert.
- R5: When several lines are pending, irqLine gives the lowest-numbered one as a binary number.
- R6: irqReq is asserted only while globalIrqEn is 1 and neither irqActive nor fiqActive is set.
- R7: irqReq and irqLine are registered. After a change to status or enable, they follow one cycle later than pendLines.
- R8: An irqAck pulse while irqReq is high sets irqActive. An irqAck pulse while irqReq is low has no effect.
- R9: fiqReq follows fiqIn one cycle later while globalFiqEn is 1 and fiqActive is clear. An fiqAck pulse while fiqReq is high sets fiqActive, and a set fiqActive blocks normal requests.
- R10: An intRet pulse clears fiqActive when it is set and leaves irqActive unchanged. Otherwise it clears irqActive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | 0 source enable, 1 source status clear, 2 video enable, 3 video status clear |
| regWrData | input | 16 | Write data |
| srcSet | input | 16 | Per-source set pulses |
| vidSet | input | 16 | Per-source video set pulses |
| fiqIn | input | 1 | Fast interrupt request level |
| globalIrqEn | input | 1 | Global normal interrupt enable |
| globalFiqEn | input | 1 | Global fast interrupt enable |
| irqAck | input | 1 | Processor accepts the normal request |
| fiqAck | input | 1 | Processor accepts the fast request |
| intRet | input | 1 | Return from an interrupt handler |
| irqReq | output | 1 | Registered normal interrupt request |
| irqLine | output | 3 | Registered number of the winning line |
| fiqReq | output | 1 | Registered fast interrupt request |
| pendLines | output | 8 | Per-line pending flags |
| statusOut | output | 16 | Source status register |
| vidStatusOut | output | 16 | Video status register |
| irqActive | output | 1 | Normal interrupt in service |
| fiqActive | output | 1 | Fast interrupt in service |

## Verification
A status bit that is lost or stuck shows on statusOut in the cycle after the pulse or clear. It then reaches pendLines in the same cycle and irqReq/irqLine one cycle later. A wrong in-service flag appears directly on irqActive or fiqActive, and in the next cycle it shows as a request that should be blocked, or one that is missing. Wrong group masks or a wrong priority scan show up as a wrong pendLines pattern or a wrong irqLine number two cycles after the stimulus.

// File: rtl/gipc_pkg.sv
package gipc_pkg;
  localparam int DATA_W    = 16;
  localparam int NUM_LINES = 8;
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam int VID_LINE  = 0;

  // group mask per line; a zero mask means the line is unused
  localparam logic [DATA_W-1:0] LINE_MASK [NUM_LINES] = '{
    16'h0000,  // 0: video pair, mask not used
    16'h0000,  // 1: unused
    16'h0C00,  // 2: general timers
    16'h2100,  // 3: serial port, converter
    16'h0000,  // 4: reserved
    16'h1200,  // 5: external pins
    16'h0070,  // 6: fast ticks
    16'h008B   // 7: base timers, slow tick, key change
  };

  typedef enum logic [1:0] {
    ADDR_EN     = 2'd0,
    ADDR_ST_CLR = 2'd1,
    ADDR_VEN    = 2'd2,
    ADDR_VST_CLR= 2'd3
  } regAddr_e;

  typedef struct packed {
    logic allowIrq;
    logic allowFiq;
  } ctrlStrb_t;
endpackage

// File: rtl/gipc_datapath.sv
module gipc_datapath
  import gipc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic [DATA_W-1:0]    srcSet,
  input  logic [DATA_W-1:0]    vidSet,
  input  logic                 fiqIn,
  input  ctrlStrb_t            strb,
  output logic [NUM_LINES-1:0] pendLines,
  output logic                 irqReq,
  output logic [LINE_W-1:0]    irqLine,
  output logic                 fiqReq,
  output logic [DATA_W-1:0]    statusOut,
  output logic [DATA_W-1:0]    vidStatusOut
);
  logic [DATA_W-1:0] enQ, stQ, vidEnQ, vidStQ;
  logic [DATA_W-1:0] stClrMask, vidClrMask;
  logic [LINE_W-1:0] winner;
  logic              anyPend;
  logic              irqReqQ, fiqReqQ;
  logic [LINE_W-1:0] irqLineQ;

  assign stClrMask  = (regWrEn && regAddr == ADDR_ST_CLR)  ? regWrData : '0;
  assign vidClrMask = (regWrEn && regAddr == ADDR_VST_CLR) ? regWrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= '0;
      stQ    <= '0;
      vidEnQ <= '0;
      vidStQ <= '0;
    end else begin
      if (regWrEn && regAddr == ADDR_EN)  enQ    <= regWrData;
      if (regWrEn && regAddr == ADDR_VEN) vidEnQ <= regWrData;
      stQ    <= (stQ & ~stClrMask) | srcSet;
      vidStQ <= (vidStQ & ~vidClrMask) | vidSet;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : gLine
      if (g == VID_LINE) begin : gVid
        assign pendLines[g] = |(vidEnQ & vidStQ);
      end else if (LINE_MASK[g] == '0) begin : gIdle
        assign pendLines[g] = 1'b0;
      end else begin : gGrp
        assign pendLines[g] = |(enQ & stQ & LINE_MASK[g]);
      end
    end
  endgenerate

  assign anyPend = |pendLines;

  always_comb begin
    winner = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pendLines[i]) winner = LINE_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReqQ  <= 1'b0;
      irqLineQ <= '0;
      fiqReqQ  <= 1'b0;
    end else begin
      irqReqQ  <= strb.allowIrq && anyPend;
      irqLineQ <= winner;
      fiqReqQ  <= strb.allowFiq && fiqIn;
    end
  end

  assign irqReq       = irqReqQ;
  assign irqLine      = irqLineQ;
  assign fiqReq       = fiqReqQ;
  assign statusOut    = stQ;
  assign vidStatusOut = vidStQ;

  logic allowIrqW, allowFiqW;
  assign allowIrqW = strb.allowIrq;
  assign allowFiqW = strb.allowFiq;

  // R2: set bits survive unless cleared
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (($past(stQ) & ~$past(stClrMask) & ~stQ) == '0));
  // R2: a set pulse always lands, even against a clear
  p_set_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((stQ & $past(srcSet)) == $past(srcSet)));
  // R6: request only when the controller allowed it
  p_req_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(allowIrqW));
  // R7: request follows a pending line by one cycle
  p_req_has_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(anyPend));
  // R9: fast request follows its input while allowed
  p_fiq_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    fiqReq |-> $past(allowFiqW && fiqIn));
endmodule

// File: rtl/gipc_ctrl.sv
module gipc_ctrl
  import gipc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      globalIrqEn,
  input  logic      globalFiqEn,
  input  logic      irqAck,
  input  logic      fiqAck,
  input  logic      intRet,
  input  logic      irqReq,
  input  logic      fiqReq,
  output ctrlStrb_t strb,
  output logic      irqActive,
  output logic      fiqActive
);
  logic irqActQ, fiqActQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqActQ <= 1'b0;
      fiqActQ <= 1'b0;
    end else if (intRet) begin
      if (fiqActQ) fiqActQ <= 1'b0;
      else         irqActQ <= 1'b0;
    end else begin
      if (fiqAck && fiqReq)             fiqActQ <= 1'b1;
      if (irqAck && irqReq && !fiqActQ) irqActQ <= 1'b1;
    end
  end

  always_comb begin
    strb.allowIrq = globalIrqEn && !irqActQ && !fiqActQ;
    strb.allowFiq = globalFiqEn && !fiqActQ;
  end

  assign irqActive = irqActQ;
  assign fiqActive = fiqActQ;

  // R8: in-service only after an acknowledged request
  p_ack_needs_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqActQ) |-> $past(irqAck && irqReq));
  // R10: a return pops the fast level first
  p_ret_fiq_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intRet && fiqActQ) |=> (!fiqActQ && irqActQ == $past(irqActQ)));
endmodule

// File: rtl/gipc_top.sv
module gipc_top
  import gipc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [15:0] regWrData,
  input  logic [15:0] srcSet,
  input  logic [15:0] vidSet,
  input  logic        fiqIn,
  input  logic        globalIrqEn,
  input  logic        globalFiqEn,
  input  logic        irqAck,
  input  logic        fiqAck,
  input  logic        intRet,
  output logic        irqReq,
  output logic [2:0]  irqLine,
  output logic        fiqReq,
  output logic [7:0]  pendLines,
  output logic [15:0] statusOut,
  output logic [15:0] vidStatusOut,
  output logic        irqActive,
  output logic        fiqActive
);
  ctrlStrb_t strb;

  gipc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .globalIrqEn(globalIrqEn), .globalFiqEn(globalFiqEn),
    .irqAck(irqAck), .fiqAck(fiqAck), .intRet(intRet),
    .irqReq(irqReq), .fiqReq(fiqReq),
    .strb(strb), .irqActive(irqActive), .fiqActive(fiqActive)
  );

  gipc_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .srcSet(srcSet), .vidSet(vidSet), .fiqIn(fiqIn), .strb(strb),
    .pendLines(pendLines), .irqReq(irqReq), .irqLine(irqLine),
    .fiqReq(fiqReq), .statusOut(statusOut), .vidStatusOut(vidStatusOut)
  );
endmodule

// File: tb/sim_gipc_top.sv
`timescale 1ns/1ps
module sim_gipc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = '0;
  logic [15:0] srcSet = '0;
  logic [15:0] vidSet = '0;
  logic        fiqIn = 1'b0;
  logic        globalIrqEn = 1'b0;
  logic        globalFiqEn = 1'b0;
  logic        irqAck = 1'b0;
  logic        fiqAck = 1'b0;
  logic        intRet = 1'b0;
  logic        irqReq, fiqReq, irqActive, fiqActive;
  logic [2:0]  irqLine;
  logic [7:0]  pendLines;
  logic [15:0] statusOut, vidStatusOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gipc_top u0 (.*);

  // en, set, vidEn, vidSet, expected pendLines, expected irqLine
  localparam logic [74:0] VEC [0:11] = '{
    {16'h0C00, 16'h0400, 16'h0000, 16'h0000, 8'h04, 3'd2},
    {16'hFFFF, 16'h2000, 16'h0000, 16'h0000, 8'h08, 3'd3},
    {16'hFFFF, 16'h0200, 16'h0000, 16'h0000, 8'h20, 3'd5},
    {16'hFFFF, 16'h0040, 16'h0000, 16'h0000, 8'h40, 3'd6},
    {16'hFFFF, 16'h0008, 16'h0000, 16'h0000, 8'h80, 3'd7},
    {16'h0000, 16'hFFFF, 16'h0001, 16'h0001, 8'h01, 3'd0},
    {16'hFFFF, 16'h00FB, 16'h0000, 16'h0000, 8'hC0, 3'd6},
    {16'h2100, 16'h1300, 16'h0000, 16'h0000, 8'h08, 3'd3},
    {16'hFFFF, 16'h0004, 16'h0000, 16'h0000, 8'h00, 3'd0},
    {16'h0070, 16'h0C00, 16'h0000, 16'h0000, 8'h00, 3'd0},
    {16'hFFFF, 16'h1000, 16'h0004, 16'h0004, 8'h21, 3'd0},
    {16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 8'hEC, 3'd2}
  };

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    cyc();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic clearAll();
    wr(2'd1, 16'hFFFF);
    wr(2'd3, 16'hFFFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    // R1 reset state
    chk("R1 irqReq", irqReq, 0);
    chk("R1 irqLine", irqLine, 0);
    chk("R1 fiqReq", fiqReq, 0);
    chk("R1 pendLines", pendLines, 0);
    chk("R1 active", {irqActive, fiqActive}, 0);
    chk("R1 status", {statusOut, vidStatusOut}, 0);
    rstN = 1'b1;
    cyc();
    globalIrqEn = 1'b1;

    // R4 R5 R7 vector table
    for (int k = 0; k < 12; k++) begin
      logic [74:0] v;
      v = VEC[k];
      clearAll();
      wr(2'd0, v[74:59]);
      wr(2'd2, v[42:27]);
      cyc();
      srcSet = v[58:43]; vidSet = v[26:11];
      cyc();
      srcSet = '0; vidSet = '0;
      chk($sformatf("R4 vec%0d pendLines", k), pendLines, v[10:3]);
      cyc();
      chk($sformatf("R5 vec%0d irqReq", k), irqReq, v[10:3] != 0);
      if (v[10:3] != 0) chk($sformatf("R5 vec%0d irqLine", k), irqLine, v[2:0]);
    end

    // R2 sticky status and set-wins
    clearAll();
    wr(2'd0, 16'h0000);
    srcSet = 16'h0020; cyc(); srcSet = '0;
    chk("R2 set", statusOut, 16'h0020);
    wr(2'd1, 16'h0001);
    chk("R2 other clear", statusOut, 16'h0020);
    srcSet = 16'h0020; regWrEn = 1'b1; regAddr = 2'd1; regWrData = 16'h0020;
    cyc();
    srcSet = '0; regWrEn = 1'b0;
    chk("R2 set wins", statusOut, 16'h0020);
    wr(2'd1, 16'h0020);
    chk("R2 clear", statusOut, 16'h0000);

    // R3 video pair
    vidSet = 16'h0300; cyc(); vidSet = '0;
    chk("R3 vid set", vidStatusOut, 16'h0300);
    wr(2'd3, 16'h0100);
    chk("R3 vid clear", vidStatusOut, 16'h0200);
    wr(2'd2, 16'h0200);
    chk("R3 vid enable", pendLines, 8'h01);
    clearAll();

    // R6 and R7 gating and latency
    globalIrqEn = 1'b0;
    wr(2'd0, 16'h0C00);
    srcSet = 16'h0800; cyc(); srcSet = '0;
    chk("R7 pend now", pendLines, 8'h04);
    chk("R7 req not yet", irqReq, 0);
    cyc();
    chk("R6 disabled", irqReq, 0);
    globalIrqEn = 1'b1;
    cyc();
    chk("R6 enabled", irqReq, 1);
    chk("R6 line", irqLine, 3'd2);

    // R8 acknowledge
    irqAck = 1'b1; cyc(); irqAck = 1'b0;
    chk("R8 active", irqActive, 1);
    cyc();
    chk("R6 blocked in service", irqReq, 0);
    intRet = 1'b1; cyc(); intRet = 1'b0;
    chk("R10 irq ret", irqActive, 0);
    clearAll();
    cyc();
    chk("R8 no req", irqReq, 0);
    irqAck = 1'b1; cyc(); irqAck = 1'b0;
    chk("R8 ack ignored", irqActive, 0);

    // R9 fast interrupt
    globalFiqEn = 1'b1; fiqIn = 1'b1;
    cyc();
    chk("R9 fiqReq", fiqReq, 1);
    fiqAck = 1'b1; cyc(); fiqAck = 1'b0;
    chk("R9 fiqActive", fiqActive, 1);
    cyc();
    chk("R9 fiqReq drop", fiqReq, 0);
    srcSet = 16'h0400; cyc(); srcSet = '0;
    cyc(); cyc();
    chk("R9 blocks irq", irqReq, 0);
    intRet = 1'b1; cyc(); intRet = 1'b0;
    fiqIn = 1'b0;
    chk("R10 fiq ret", fiqActive, 0);
    cyc();
    chk("R9 irq after fiq", irqReq, 1);

    // R10 nested return order
    irqAck = 1'b1; cyc(); irqAck = 1'b0;
    fiqIn = 1'b1; cyc();
    chk("R10 fiq offered", fiqReq, 1);
    fiqAck = 1'b1; cyc(); fiqAck = 1'b0; fiqIn = 1'b0;
    chk("R10 both", {irqActive, fiqActive}, 2'b11);
    intRet = 1'b1; cyc(); intRet = 1'b0;
    chk("R10 fiq first", {irqActive, fiqActive}, 2'b10);
    intRet = 1'b1; cyc(); intRet = 1'b0;
    chk("R10 irq second", {irqActive, fiqActive}, 2'b00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule